// File: doc/BRIEF.md
# Signal Trace Capture Scope

This block is an embedded logic analyser for a large chip. When it is armed, it records a fixed-width frame of probe signals on every clock into an on-chip buffer. Sampling stops when the buffer is full, and the capture is then flagged valid. Arming usually comes from the accelerator's run command.

A host reads the capture through two registers. The first is a small command register. The second is a 64-bit data register whose meaning depends on the command. Through the data register the host can read the valid flag, the frame width and the buffer depth. It can also stream out the captured samples as a continuous bit stream.

Frames are packed back to back with no padding, so one frame may straddle two readout words. Once the whole stream has been read, the buffer counts as drained and the scope accepts a new arm.

Top module: `trace_scope`

## Requirements
- R1: After reset the command register holds 0, the valid flag is 0 and the stream read position is past the end, so a stream read returns zero.
- R2: `cmd_we_i` loads `cmd_i` into the command register, which takes effect on the next cycle. The data register then returns one of four values. Command 0 gives the valid flag in bit 0 with all other bits zero. Command 1 gives the current 64-bit stream word. Command 2 gives FRAME_W. Command 3 gives DEPTH.
- R3: An arm pulse is accepted only while the scope is idle, meaning no capture is running and no capture is waiting. Frame f (f = 0..DEPTH-1) is the value of `probe_i` at the (f+1)-th rising edge after the edge that accepted the arm.
- R4: The valid flag is 0 until the DEPTH-th sample has been written and reads 1 from the cycle after it. No further samples are taken after that.
- R5: Bit b of frame f sits at stream position f*FRAME_W+b. Stream word w carries positions 64w to 64w+63, with position 64w in data bit 0.
- R6: The stream read position advances by one word only when `rd_en_i` is high, the command register holds 1 and the valid flag is 1. Changing the command and reading under other commands leave it unchanged.
- R7: The valid flag stays 1 up to and including the cycle of the read of the last word, which is word ceil(DEPTH*FRAME_W/64)-1. It reads 0 from the next cycle on.
- R8: Stream bits beyond DEPTH*FRAME_W, and stream reads after the last word, return zero.
- R9: An arm pulse is ignored while a capture is running or waiting. This includes an arm that coincides with the read of the last word. Captured data is not overwritten in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse that starts a capture when idle |
| probe_i | input | FRAME_W | Probe signals sampled every cycle during capture |
| cmd_we_i | input | 1 | Write strobe for the command register |
| cmd_i | input | 2 | Command value written by cmd_we_i |
| rd_en_i | input | 1 | Data register read strobe |
| rd_data_o | output | 64 | Data register contents, selected by the command register |

## Verification
Two events can fall in the same cycle: the read of the last stream word, which drains the buffer, and an arm pulse. The bench provokes this by driving `arm_i` together with the final `rd_en_i`. It then requires three things. The valid flag must read 0 afterwards. No capture may start, so the flag must stay 0 for more than DEPTH cycles and stream reads must return zero. A later stand-alone arm must run a full new capture whose stream matches the new probe pattern.

// File: rtl/trace_scope_pkg.sv
package trace_scope_pkg;
  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    SCMD_VALID  = 2'd0,
    SCMD_STREAM = 2'd1,
    SCMD_FWIDTH = 2'd2,
    SCMD_DEPTH  = 2'd3
  } scope_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_DONE = 2'd2
  } scope_st_e;
endpackage

// File: rtl/scope_ctrl.sv
module scope_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             drain_last_i,
  output logic             start_o,
  output logic             we_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             valid_o,
  output logic             capturing_o
);
  import trace_scope_pkg::*;

  scope_st_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_frame;

  assign last_frame = (idx_q == IDX_W'(DEPTH - 1));
  assign start_o    = arm_i && (st_q == ST_IDLE);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: if (arm_i) begin
        st_d  = ST_CAPT;
        idx_d = '0;
      end
      ST_CAPT: begin
        if (last_frame) begin
          st_d  = ST_DONE;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DONE: if (drain_last_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign we_o        = (st_q == ST_CAPT);
  assign wr_idx_o    = idx_q;
  assign valid_o     = (st_q == ST_DONE);
  assign capturing_o = (st_q == ST_CAPT);
endmodule

// File: rtl/scope_store.sv
module scope_store #(
  parameter int FRAME_W = 85,
  parameter int DEPTH   = 16,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BUF_W  = FRAME_W * DEPTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [FRAME_W-1:0] probe_i,
  output logic [BUF_W-1:0]   flat_o
);
  logic [FRAME_W-1:0] frame_q [DEPTH];

  for (genvar f = 0; f < DEPTH; f++) begin : g_frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    frame_q[f] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(f)))       frame_q[f] <= probe_i;
    end
    // frame f occupies a contiguous slice of the stream
    assign flat_o[f*FRAME_W +: FRAME_W] = frame_q[f];
  end
endmodule

// File: rtl/scope_readout.sv
module scope_readout #(
  parameter int FRAME_W = 85,
  parameter int DEPTH   = 16,
  localparam int WW     = trace_scope_pkg::WORD_W,
  localparam int BUF_W  = FRAME_W * DEPTH,
  localparam int TOTAL  = (BUF_W + WW - 1) / WW,
  localparam int PTR_W  = $clog2(TOTAL + 1),
  localparam int PAD_W  = (TOTAL + 1) * WW,
  localparam int BASE_W = PTR_W + $clog2(WW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [1:0]       cmd_i,
  input  logic             rd_en_i,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [BUF_W-1:0] flat_i,
  output logic [WW-1:0]    rd_data_o,
  output logic             drain_last_o,
  output logic [1:0]       cmd_o,
  output logic [PTR_W-1:0] ptr_o
);
  import trace_scope_pkg::*;

  scope_cmd_e        cmd_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PAD_W-1:0]  stream;
  logic [BASE_W-1:0] base;
  logic              adv;

  assign stream = {{(PAD_W - BUF_W){1'b0}}, flat_i};
  assign base   = BASE_W'(ptr_q) << $clog2(WW);
  assign adv    = rd_en_i && (cmd_q == SCMD_STREAM) && valid_i && (ptr_q < PTR_W'(TOTAL));
  assign drain_last_o = adv && (ptr_q == PTR_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= SCMD_VALID;
      ptr_q <= PTR_W'(TOTAL);
    end else begin
      if (cmd_we_i) cmd_q <= scope_cmd_e'(cmd_i);
      if (start_i)  ptr_q <= '0;
      else if (adv) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_comb begin
    unique case (cmd_q)
      SCMD_VALID:  rd_data_o = {{(WW-1){1'b0}}, valid_i};
      SCMD_STREAM: rd_data_o = (ptr_q < PTR_W'(TOTAL)) ? stream[base +: WW] : '0;
      SCMD_FWIDTH: rd_data_o = WW'(FRAME_W);
      SCMD_DEPTH:  rd_data_o = WW'(DEPTH);
      default:     rd_data_o = '0;
    endcase
  end

  assign cmd_o = cmd_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/trace_scope.sv
module trace_scope #(
  parameter int FRAME_W = 85,
  parameter int DEPTH   = 16,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BUF_W  = FRAME_W * DEPTH,
  localparam int TOTAL  = (BUF_W + 63) / 64,
  localparam int PTR_W  = $clog2(TOTAL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic [FRAME_W-1:0] probe_i,
  input  logic               cmd_we_i,
  input  logic [1:0]         cmd_i,
  input  logic               rd_en_i,
  output logic [63:0]        rd_data_o
);
  logic             start_w, we_w, valid_w, capt_w, drain_w;
  logic [IDX_W-1:0] idx_w;
  logic [BUF_W-1:0] flat_w;
  logic [1:0]       cmd_w;
  logic [PTR_W-1:0] ptr_w;

  scope_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i, .rst_ni, .arm_i,
    .drain_last_i(drain_w),
    .start_o(start_w),
    .we_o(we_w),
    .wr_idx_o(idx_w),
    .valid_o(valid_w),
    .capturing_o(capt_w)
  );

  scope_store #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) store_i (
    .clk_i, .rst_ni,
    .we_i(we_w),
    .wr_idx_i(idx_w),
    .probe_i,
    .flat_o(flat_w)
  );

  scope_readout #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) rdout_i (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_i, .rd_en_i,
    .start_i(start_w),
    .valid_i(valid_w),
    .flat_i(flat_w),
    .rd_data_o,
    .drain_last_o(drain_w),
    .cmd_o(cmd_w),
    .ptr_o(ptr_w)
  );
endmodule

// File: rtl/trace_scope_chk.sv
module trace_scope_chk #(
  parameter int FRAME_W = 85,
  parameter int DEPTH   = 16,
  localparam int TOTAL  = (FRAME_W * DEPTH + 63) / 64,
  localparam int PTR_W  = $clog2(TOTAL + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             rd_en_i,
  input logic             valid_i,
  input logic             capturing_i,
  input logic [1:0]       cmd_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic [63:0]      rd_data_i
);
  logic [CNT_W-1:0] samples_q;
  logic             idle;

  assign idle = !valid_i && !capturing_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              samples_q <= '0;
    else if (arm_i && idle)   samples_q <= '0;
    else if (capturing_i)     samples_q <= samples_q + 1'b1;
  end

  a_r4_full_before_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> (samples_q == CNT_W'(DEPTH)));

  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rd_en_i && cmd_i == 2'd1 && valid_i) && !(arm_i && idle)) |=> $stable(ptr_i));

  a_r7_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_i) |-> $past(rd_en_i && cmd_i == 2'd1 && ptr_i == PTR_W'(TOTAL - 1)));

  a_r8_zero_past_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 && ptr_i >= PTR_W'(TOTAL)) |-> (rd_data_i == 64'd0));

  a_r9_no_rearm_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && arm_i) |=> !capturing_i);

  a_r2_width_query: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2) |-> (rd_data_i == 64'(FRAME_W)));

  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && capturing_i));
endmodule

bind trace_scope trace_scope_chk #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .arm_i(arm_i),
  .rd_en_i(rd_en_i),
  .valid_i(valid_w),
  .capturing_i(capt_w),
  .cmd_i(cmd_w),
  .ptr_i(ptr_w),
  .rd_data_i(rd_data_o)
);

// File: tb/trace_scope_tb_top.sv
`timescale 1ns/1ps
module trace_scope_tb_top;
  localparam int FW = 85;
  localparam int D  = 16;
  localparam int TW = (FW * D + 63) / 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic [FW-1:0] probe = '0;
  logic          cmd_we = 1'b0;
  logic [1:0]    cmd = 2'd0;
  logic          rd_en = 1'b0;
  logic [63:0]   rd_data;

  int checks = 0;
  int failures = 0;
  logic [FW-1:0] exp_fr [D];

  always #2 clk = ~clk;

  trace_scope #(.FRAME_W(FW), .DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .probe_i(probe),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .rd_en_i(rd_en), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pat(input int s, input int f);
    int unsigned a;
    logic [127:0] x;
    if (s == 0) return '1;
    a = s * 32'd2654435761 + f * 32'd40503 + 32'd1;
    x = {a, a ^ 32'hDEADBEEF, a * 32'd3, ~a};
    return x[FW-1:0];
  endfunction

  function automatic logic [63:0] exp_word(input int w);
    logic [63:0] r;
    for (int j = 0; j < 64; j++) begin
      int k;
      k = w * 64 + j;
      r[j] = (k < FW * D) ? exp_fr[k / FW][k % FW] : 1'b0;
    end
    return r;
  endfunction

  // called at a negedge, returns at a negedge with the command in effect
  task automatic set_cmd(input logic [1:0] c);
    cmd_we = 1'b1; cmd = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic rd_word(output logic [63:0] d, input bit with_arm);
    d = rd_data;
    rd_en = 1'b1; arm = with_arm;
    @(negedge clk);
    rd_en = 1'b0; arm = 1'b0;
  endtask

  task automatic capture(input int s);
    logic [63:0] d;
    set_cmd(2'd0);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int f = 0; f < D; f++) begin
      probe = pat(s, f);
      exp_fr[f] = pat(s, f);
      if (f == D - 1) chk(rd_data == 64'd0, "R4 valid low before last sample", rd_data, 64'd0);
      @(negedge clk);
    end
    probe = ~probe;
    d = rd_data;
    chk(d == 64'd1, "R4 valid after DEPTH samples", d, 64'd1);
  endtask

  task automatic drain(input bit arm_last);
    logic [63:0] d;
    set_cmd(2'd1);
    for (int w = 0; w < TW; w++) begin
      if (w == 5) begin
        set_cmd(2'd2);
        rd_word(d, 1'b0);
        chk(d == 64'(FW), "R2 width query", d, 64'(FW));
        set_cmd(2'd3);
        rd_word(d, 1'b0);
        chk(d == 64'(D), "R2 depth query", d, 64'(D));
        set_cmd(2'd1);
      end
      if (w == TW - 1) begin
        set_cmd(2'd0);
        chk(rd_data == 64'd1, "R7 valid before last word", rd_data, 64'd1);
        set_cmd(2'd1);
      end
      rd_word(d, arm_last && (w == TW - 1));
      chk(d == exp_word(w), (w == 5) ? "R6 pointer held across other commands" : "R5 stream word", d, exp_word(w));
    end
    set_cmd(2'd0);
    chk(rd_data == 64'd0, "R7 valid low after drain", rd_data, 64'd0);
    set_cmd(2'd1);
    for (int i = 0; i < 2; i++) begin
      rd_word(d, 1'b0);
      chk(d == 64'd0, "R8 read past end", d, 64'd0);
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rd_data == 64'd0, "R1 valid after reset", rd_data, 64'd0);
    set_cmd(2'd1);
    rd_word(d, 1'b0);
    chk(d == 64'd0, "R1 stream after reset", d, 64'd0);
    set_cmd(2'd2);
    chk(rd_data == 64'(FW), "R2 width", rd_data, 64'(FW));
    set_cmd(2'd3);
    chk(rd_data == 64'(D), "R2 depth", rd_data, 64'(D));

    // R3: first capture, then R9 arm while waiting
    capture(5);
    for (int i = 0; i < D + 2; i++) begin
      arm = 1'b1; probe = pat(7, i);
      @(negedge clk);
    end
    arm = 1'b0;
    chk(rd_data == 64'd1, "R9 valid kept under arm", rd_data, 64'd1);
    drain(1'b0);

    // all-ones capture; arm coincides with final read
    capture(0);
    drain(1'b1);
    set_cmd(2'd0);
    for (int i = 0; i < D + 4; i++) begin
      probe = pat(11, i);
      @(negedge clk);
    end
    chk(rd_data == 64'd0, "R9 arm on last read ignored", rd_data, 64'd0);
    set_cmd(2'd1);
    rd_word(d, 1'b0);
    chk(d == 64'd0, "R9 no capture after ignored arm", d, 64'd0);

    // R3: fresh arm after drain
    capture(9);
    drain(1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule